// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Processor Core

This block is a small 16-bit processor that takes several clock cycles per instruction. A single memory port carries both instruction fetches and data loads and stores. The core holds a program counter, an instruction register, eight general 16-bit registers, one shared ALU and a control state machine. The ALU does the register arithmetic, forms load and store addresses, increments the program counter and computes branch targets.

The core is reset into its fetch state. From there it runs from word address 0 until it reaches a stop instruction. The memory attached to the port is word-addressed. It must return read data on the clock edge that follows the cycle in which `mem_rd` and the address were presented.

The control machine has twelve named states:
- `S_FETCH` presents the PC and increments it.
- `S_IRLOAD` captures the returned word.
- `S_DECODE` branches on the opcode. It goes to `S_ALU`, `S_ADDI`, `S_LWADDR`, `S_SW`, `S_BEQCMP`, `S_JUMP` or `S_HALT`, or back to `S_FETCH` for opcode 6.
- `S_LWADDR` is followed by `S_LWWB`.
- `S_BEQCMP` is followed by `S_BEQTGT`.
- `S_HALT` loops on itself.
- Every other execute state returns to `S_FETCH`.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high reset sets the PC and all eight registers to zero and puts the machine in fetch. While reset is held, mem_addr is 0, mem_rd is 1, mem_wr is 0 and halted is 0.
- R2: In a fetch cycle mem_addr equals the PC and mem_rd is 1, and the PC becomes PC+1 through the ALU. The word read back on the next cycle is loaded into the instruction register.
- R3: Instruction fields are opcode [15:13], first source rs [12:10], second source/target rt [9:7], destination rd [6:4] and function [3:0]. Opcode 0 with function 0, 1, 2, 3 or 4 writes rd with rs+rt, rs-rt, rs&rt, rs|rt, or 1 when rs is less than rt as signed values (else 0).
- R4: Opcode 0 with a function value of 5 to 15 writes no register.
- R5: Opcode 1 (load) writes rt with the memory word at rs plus the offset. The offset is bits [6:0], sign-extended.
- R6: Opcode 2 (store) raises mem_wr for one cycle, with mem_addr = rs + sign-extended offset and mem_wdata = rt.
- R7: Opcode 4 writes rt with rs plus the sign-extended 7-bit offset.
- R8: Opcode 3 compares rs and rt. When they are equal, the PC becomes the already incremented PC plus the sign-extended offset. Otherwise execution continues at the next word.
- R9: Opcode 5 loads the PC with bits [12:0] zero-extended to 16 bits.
- R10: Opcode 6 changes no register and no memory word, and execution continues at the next word.
- R11: Opcode 7 enters a stop state. There halted is 1 and mem_rd and mem_wr are 0 on every cycle until reset.
- R12: From reset release, a stop instruction raises halted after 3 clock edges. Each instruction before it adds the following number of edges: no-op 3, register op 4, add-immediate 4, store 4, jump 4, load 5, branch 5.
- R13: mem_rd and mem_wr are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for a store |
| mem_wdata | output | 16 | Store data (value of rt) |
| mem_rdata | input | 16 | Read data returned by memory |
| halted | output | 1 | High while the core sits in the stop state |

## Verification
The embedded properties watch rules that hold every cycle: the two strobes are exclusive, the stop state is quiet and sticky, every fetch advances the PC by one, the fetched word lands in the instruction register, a write occurs only under a store opcode, and a jump loads the zero-extended target. Arithmetic results, the signed set-less-than, sign extension of offsets, branch taken versus not taken, ignored function codes and exact cycle counts only show up in the bench's programs. Those programs store registers back to memory, where the bench compares them with values it computes itself.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
    localparam int WORD_W = 16;
    localparam int RIDX_W = 3;
    localparam int OFF_W  = 7;
    localparam int TGT_W  = 13;

    localparam logic [2:0] OP_REG  = 3'd0;
    localparam logic [2:0] OP_LOAD = 3'd1;
    localparam logic [2:0] OP_STOR = 3'd2;
    localparam logic [2:0] OP_BREQ = 3'd3;
    localparam logic [2:0] OP_ADDI = 3'd4;
    localparam logic [2:0] OP_JMP  = 3'd5;
    localparam logic [2:0] OP_STOP = 3'd7;

    typedef enum logic [3:0] {
        S_FETCH, S_IRLOAD, S_DECODE, S_ALU, S_ADDI, S_LWADDR,
        S_LWWB, S_SW, S_BEQCMP, S_BEQTGT, S_JUMP, S_HALT
    } state_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_t;

    typedef enum logic {A_PC, A_RS} a_sel_t;
    typedef enum logic [1:0] {B_RT, B_ONE, B_OFF} b_sel_t;

    typedef struct packed {
        logic    pc_load;
        logic    pc_jump;
        logic    ir_load;
        logic    rf_we;
        logic    rf_to_rt;
        logic    rf_from_mem;
        a_sel_t  a_sel;
        b_sel_t  b_sel;
        alu_op_t alu_op;
        logic    addr_alu;
        logic    mem_rd;
        logic    mem_wr;
        logic    zf_load;
        logic    halted;
    } ctrl_t;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_t      op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic lt;

    always_comb begin
        lt = ($signed(a) < $signed(b));
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] sel_a,
    input  logic [AW-1:0] sel_b,
    input  logic [AW-1:0] sel_w,
    input  logic [W-1:0]  wdata,
    input  logic          we,
    output logic [W-1:0]  val_a,
    output logic [W-1:0]  val_b
);
    localparam int N = 1 << AW;

    logic [W-1:0] bank [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) bank[i] <= '0;
        end else if (we) begin
            bank[sel_w] <= wdata;
        end
    end

    assign val_a = bank[sel_a];
    assign val_b = bank[sel_b];
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] opcode,
    input  logic [3:0] funct,
    input  logic       zflag,
    output state_t     state,
    output ctrl_t      ctl
);
    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_IRLOAD;
            S_IRLOAD: nxt = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_REG:  nxt = S_ALU;
                    OP_LOAD: nxt = S_LWADDR;
                    OP_STOR: nxt = S_SW;
                    OP_BREQ: nxt = S_BEQCMP;
                    OP_ADDI: nxt = S_ADDI;
                    OP_JMP:  nxt = S_JUMP;
                    OP_STOP: nxt = S_HALT;
                    default: nxt = S_FETCH;
                endcase
            end
            S_LWADDR: nxt = S_LWWB;
            S_BEQCMP: nxt = S_BEQTGT;
            S_HALT:   nxt = S_HALT;
            default:  nxt = S_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH: begin
                ctl.mem_rd  = 1'b1;
                ctl.a_sel   = A_PC;
                ctl.b_sel   = B_ONE;
                ctl.alu_op  = ALU_ADD;
                ctl.pc_load = 1'b1;
            end
            S_IRLOAD: ctl.ir_load = 1'b1;
            S_ALU: begin
                ctl.a_sel = A_RS;
                ctl.b_sel = B_RT;
                ctl.rf_we = (funct <= 4'd4);
                case (funct)
                    4'd1:    ctl.alu_op = ALU_SUB;
                    4'd2:    ctl.alu_op = ALU_AND;
                    4'd3:    ctl.alu_op = ALU_OR;
                    4'd4:    ctl.alu_op = ALU_SLT;
                    default: ctl.alu_op = ALU_ADD;
                endcase
            end
            S_ADDI: begin
                ctl.a_sel    = A_RS;
                ctl.b_sel    = B_OFF;
                ctl.rf_we    = 1'b1;
                ctl.rf_to_rt = 1'b1;
            end
            S_LWADDR: begin
                ctl.a_sel    = A_RS;
                ctl.b_sel    = B_OFF;
                ctl.addr_alu = 1'b1;
                ctl.mem_rd   = 1'b1;
            end
            S_LWWB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_to_rt    = 1'b1;
                ctl.rf_from_mem = 1'b1;
            end
            S_SW: begin
                ctl.a_sel    = A_RS;
                ctl.b_sel    = B_OFF;
                ctl.addr_alu = 1'b1;
                ctl.mem_wr   = 1'b1;
            end
            S_BEQCMP: begin
                ctl.a_sel   = A_RS;
                ctl.b_sel   = B_RT;
                ctl.alu_op  = ALU_SUB;
                ctl.zf_load = 1'b1;
            end
            S_BEQTGT: begin
                ctl.a_sel   = A_PC;
                ctl.b_sel   = B_OFF;
                ctl.pc_load = zflag;
            end
            S_JUMP: begin
                ctl.pc_load = 1'b1;
                ctl.pc_jump = 1'b1;
            end
            S_HALT: ctl.halted = 1'b1;
            default: ;
        endcase
    end

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |=> (state == S_HALT));

    p_store_only_op_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |-> (opcode == OP_STOR));
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic [WORD_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                halted
);
    localparam int EXT_W = WORD_W - OFF_W;
    localparam int PAD_W = WORD_W - TGT_W;

    logic [WORD_W-1:0] pc, ir, rs_val, rt_val, alu_a, alu_b, alu_y, off_ext, tgt_ext;
    logic              alu_zero, zflag;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
    state_t            state;
    ctrl_t             ctl;

    assign rs_idx  = ir[12:10];
    assign rt_idx  = ir[9:7];
    assign rd_idx  = ir[6:4];
    assign off_ext = {{EXT_W{ir[OFF_W-1]}}, ir[OFF_W-1:0]};
    assign tgt_ext = {{PAD_W{1'b0}}, ir[TGT_W-1:0]};

    cpu16_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir[15:13]),
        .funct  (ir[3:0]),
        .zflag  (zflag),
        .state  (state),
        .ctl    (ctl)
    );

    cpu16_regfile #(.W(WORD_W), .AW(RIDX_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .sel_a (rs_idx),
        .sel_b (rt_idx),
        .sel_w (ctl.rf_to_rt ? rt_idx : rd_idx),
        .wdata (ctl.rf_from_mem ? mem_rdata : alu_y),
        .we    (ctl.rf_we),
        .val_a (rs_val),
        .val_b (rt_val)
    );

    always_comb begin
        alu_a = (ctl.a_sel == A_PC) ? pc : rs_val;
        case (ctl.b_sel)
            B_ONE:   alu_b = {{(WORD_W-1){1'b0}}, 1'b1};
            B_OFF:   alu_b = off_ext;
            default: alu_b = rt_val;
        endcase
    end

    cpu16_alu #(.W(WORD_W)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ir    <= '0;
            zflag <= 1'b0;
        end else begin
            if (ctl.pc_load) pc <= ctl.pc_jump ? tgt_ext : alu_y;
            if (ctl.ir_load) ir <= mem_rdata;
            if (ctl.zf_load) zflag <= alu_zero;
        end
    end

    assign mem_addr  = ctl.addr_alu ? alu_y : pc;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign mem_wdata = rt_val;
    assign halted    = ctl.halted;

    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (pc == $past(pc) + 16'd1));

    p_ir_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IRLOAD) |=> (ir == $past(mem_rdata)));

    p_jump_dest_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_JUMP) |=> (pc == {3'b000, $past(ir[12:0])}));
endmodule

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] STOP_W = 16'hE000;
    localparam logic [15:0] NOP_W  = 16'hC000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;

    logic [15:0] mem  [64];
    logic [15:0] prog [64];
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu16_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    end

    function automatic logic [15:0] rt_w(int rs, int rt, int rd, int f);
        return {3'd0, rs[2:0], rt[2:0], rd[2:0], f[3:0]};
    endfunction

    function automatic logic [15:0] it_w(int op, int rs, int rt, int off);
        return {op[2:0], rs[2:0], rt[2:0], off[6:0]};
    endfunction

    function automatic logic [15:0] jt_w(int tgt);
        return {3'd5, tgt[12:0]};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = STOP_W;
    endtask

    task automatic run(int max_cyc, output int n);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            ld_en = 1'b1; ld_addr = i[5:0]; ld_data = prog[i];
            @(posedge clk); #1;
        end
        ld_en = 1'b0;
        @(negedge clk);
        check("R1 reset addr", mem_addr, 16'h0000);
        check("R1 reset strobes", {14'd0, mem_rd, mem_wr}, 16'h0002);
        check("R1 reset halted", {15'd0, halted}, 16'h0000);
        rst = 1'b0;
        n = 0;
        while (!halted && n < max_cyc) begin
            @(posedge clk); #1;
            n++;
        end
        if (!halted) begin
            checks++; failures++;
            $display("FAIL watchdog run actual=%0d expected<%0d", n, max_cyc);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog global actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        int n;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'h00FF; vals[7] = 16'hFF00;

        // R3 R5 R6: sweep register ops over operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] a, b;
                a = vals[i]; b = vals[j];
                clear_prog();
                prog[0] = it_w(1, 0, 1, 60);
                prog[1] = it_w(1, 0, 2, 61);
                for (int f = 0; f < 5; f++) prog[2+f] = rt_w(1, 2, 3+f, f);
                for (int k = 0; k < 5; k++) prog[7+k] = it_w(2, 0, 3+k, 40+k);
                prog[60] = a; prog[61] = b;
                run(500, n);
                check("R3 add", mem[40], a + b);
                check("R3 sub", mem[41], a - b);
                check("R3 and", mem[42], a & b);
                check("R3 or",  mem[43], a | b);
                check("R3 slt", mem[44], ($signed(a) < $signed(b)) ? 16'd1 : 16'd0);
            end
        end

        // R4: unused function codes leave rd alone
        for (int f = 5; f < 16; f++) begin
            clear_prog();
            prog[0] = it_w(4, 0, 6, 33);
            prog[1] = it_w(4, 0, 1, 5);
            prog[2] = rt_w(1, 1, 6, f);
            prog[3] = it_w(2, 0, 6, 43);
            run(200, n);
            check("R4 funct ignored", mem[43], 16'd33);
        end

        // R7 R8 R9 R10 R11: mixed control program
        clear_prog();
        prog[0]  = it_w(4, 0, 1, -5);
        prog[1]  = it_w(4, 0, 2, 10);
        prog[2]  = it_w(4, 0, 3, 10);
        prog[3]  = it_w(3, 2, 3, 2);
        prog[4]  = it_w(4, 0, 4, 1);
        prog[5]  = it_w(4, 0, 4, 2);
        prog[6]  = it_w(3, 1, 2, 5);
        prog[7]  = it_w(4, 0, 5, 7);
        prog[8]  = it_w(4, 0, 6, 33);
        prog[9]  = NOP_W;
        prog[10] = rt_w(1, 2, 6, 9);
        prog[11] = jt_w(14);
        prog[12] = it_w(4, 0, 7, 1);
        prog[13] = STOP_W;
        prog[14] = it_w(2, 0, 1, 40);
        prog[15] = it_w(2, 0, 4, 41);
        prog[16] = it_w(2, 0, 5, 42);
        prog[17] = it_w(2, 0, 6, 43);
        prog[18] = it_w(2, 0, 7, 44);
        run(500, n);
        check("R7 addi negative", mem[40], 16'hFFFB);
        check("R8 beq taken skips", mem[41], 16'h0000);
        check("R8 beq not taken", mem[42], 16'h0007);
        check("R10 nop", mem[43], 16'd33);
        check("R9 jump skips", mem[44], 16'h0000);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R11 stop held", {14'd0, halted, mem_rd | mem_wr}, 16'h0002);
        end
        check("R11 memory still", mem[40], 16'hFFFB);

        // R5 R7: negative offsets on load/store, extreme addi offset
        clear_prog();
        prog[0] = it_w(4, 0, 1, 63);
        prog[1] = it_w(1, 1, 2, -3);
        prog[2] = it_w(2, 1, 2, -2);
        prog[3] = it_w(4, 0, 3, -64);
        prog[4] = it_w(2, 0, 3, 62);
        prog[60] = 16'hBEEF;
        run(300, n);
        check("R5 load neg offset", mem[61], 16'hBEEF);
        check("R7 addi -64", mem[62], 16'hFFC0);

        // R1: reset clears registers that a prior run set
        clear_prog();
        for (int k = 0; k < 8; k++) prog[k] = it_w(2, 0, k, 40+k);
        prog[8] = STOP_W;
        for (int k = 0; k < 8; k++) prog[40+k] = 16'hAAAA;
        run(300, n);
        for (int k = 0; k < 8; k++) check("R1 regs cleared", mem[40+k], 16'h0000);

        // R12: exact cycle count
        clear_prog();
        run(100, n);
        check("R12 stop alone", n[15:0], 16'd3);
        clear_prog();
        prog[0] = NOP_W;
        prog[1] = it_w(4, 0, 1, 1);
        prog[2] = it_w(1, 0, 2, 60);
        prog[3] = it_w(2, 0, 2, 61);
        prog[4] = it_w(3, 0, 0, 0);
        prog[5] = jt_w(6);
        prog[6] = rt_w(1, 1, 3, 0);
        prog[7] = STOP_W;
        prog[60] = 16'h5A5A;
        prog[61] = 16'h0000;
        run(200, n);
        check("R12 mixed count", n[15:0], 16'd32);
        check("R6 store data", mem[61], 16'h5A5A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule